// File: doc/BRIEF.md
# Dual-Slope PWM Timer Channel

This block is one timer channel that produces a symmetric, centre-aligned PWM waveform. An 8-bit counter climbs from 0 to 255 and then falls back to 0. The climb from 0 to 255 takes 255 counting steps and the fall takes another 255, so a full waveform period is 510 counting steps. A prescaler decides how often the counter steps. It either divides the system clock by one of seven fixed ratios or holds the counter still.

A single compare channel turns the counter position into a pin level. The host writes a compare value into a holding buffer. That value is copied into the active compare register only when the counter arrives at its top value (255). As a result, every period from one top to the next uses one constant threshold, and the high pulse stays centred on the counter's bottom. Two sticky event flags, one for bottom and one for compare hits, can be cleared by the host writing a 1.

The output is driven from the counter state and the active threshold rather than from toggles applied at match events. The two threshold extremes therefore give a steady level. When the threshold drops from its maximum, the output still steps to the correct level at the top, even though no match occurs there.

Top module: `pwm_phase_timer`

## Requirements
- R1: After reset the count is 0 and counting upward. With steps enabled, the count goes 0,1,…,255,254,…,1,0,1,… so that it visits bottom once every 510 steps.
- R2: The divide select `clkSel` picks the step rate: 1→every clock, 2→/8, 3→/32, 4→/64, 5→/128, 6→/256, 7→/1024; 0 holds the count. On the clock edge where a new select value is first seen, the prescaler restarts and produces no step. The first step then lands N edges later and every N edges after that.
- R3: `ovfFlag` becomes 1 on the step that brings the count to 0.
- R4: `cmpFlag` becomes 1 on every step whose new count equals the active compare value, whether counting up or down.
- R5: Each flag stays at 1 until its clear input is 1 at a clock edge. If that edge also carries a set event, the flag stays at 1.
- R6: In `modeSel`=2 (true polarity) with active compare value k, the pin is high while descending at counts k down to 1, at 0, and while ascending at counts 1 to k-1. That makes 2k high steps per 510-step period. A value of 0 gives a constant low and a value of 255 gives a constant high.
- R7: `modeSel`=3 gives the complement of the R6 level, so a period has 510-2k high steps.
- R8: `modeSel`=0 or 1 forces `pwmOut` and `pwmOutEn` to 0. With `modeSel`=2 or 3, `pwmOutEn` is 1.
- R9: A value written through `cmpWrEn`/`cmpWrData` does not affect the pin or the compare flag until the step that brings the count to 255. That step loads it.
- R10: At count 255 the pin shows the result of an ascending match with the newly loaded value: low for any value below 255 (true polarity). A value leaving 255 therefore gives a pin transition at the top without any match.
- R11: Out of reset both flags are 0, `pwmOut` and `pwmOutEn` are 0, and the active and buffered compare values are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkSel | input | 3 | Step-rate select (0 holds) |
| modeSel | input | 2 | Pin mode: 0/1 off, 2 true, 3 inverted |
| cmpWrEn | input | 1 | Host write strobe for the compare buffer |
| cmpWrData | input | CNT_W | Compare value to buffer |
| flagClrOvf | input | 1 | Write-1 clear of the bottom flag |
| flagClrCmp | input | 1 | Write-1 clear of the compare flag |
| cntValue | output | CNT_W | Current counter value |
| pwmOut | output | 1 | PWM pin level |
| pwmOutEn | output | 1 | Pin drive enable |
| ovfFlag | output | 1 | Sticky bottom-reached flag |
| cmpFlag | output | 1 | Sticky compare-hit flag |

## Verification
The duty check covers every compare value from 0 to 255 in true polarity, with the threshold reloaded at each top. It counts the high steps over one full period, so an off-by-one at either slope shows up as a count other than 2k, and the two extremes confirm the constant levels. Inverted polarity is tried at both ends of the range, where the complement is easiest to get wrong. Separate patterns check the following:
- a write in mid-period from 255 to 0, which separates buffered from immediate loading and shows the transition at the top without a match;
- a flag clear that coincides with a bottom arrival, which separates set priority from clear priority;
- each divide ratio entered from a different previous select, which shows that the prescaler restarts.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  localparam int unsigned MAX_DIV = 1024;
  localparam int unsigned PRE_W   = $clog2(MAX_DIV);
  localparam int unsigned SEL_W   = 3;

  typedef struct packed {
    logic tick;         // counter steps this cycle
    logic enterTop;     // this step lands on the top value
    logic enterBottom;  // this step lands on zero
    logic descending;   // current state lies on the falling slope
  } pwmStrobeT;

  typedef enum logic [1:0] {
    OUT_OFF  = 2'd0,
    OUT_RSVD = 2'd1,
    OUT_TRUE = 2'd2,
    OUT_INV  = 2'd3
  } outModeT;

  function automatic int unsigned divRatio(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd2:    return 8;
      3'd3:    return 32;
      3'd4:    return 64;
      3'd5:    return 128;
      3'd6:    return 256;
      3'd7:    return MAX_DIV;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] clkSel,
  output logic             tick
);

  logic [SEL_W-1:0] selQ;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLimit;
  logic             selChanged;
  logic             running;

  always_comb begin
    selChanged = (clkSel != selQ);
    running    = (clkSel != '0);
    preLimit   = PRE_W'(divRatio(clkSel) - 1);
    tick       = running && !selChanged && (preCnt == preLimit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ   <= '0;
      preCnt <= '0;
    end else begin
      selQ <= clkSel;
      if (selChanged || !running || tick) preCnt <= '0;
      else                                preCnt <= preCnt + PRE_W'(1);
    end
  end

endmodule

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] clkSel,
  input  logic [CNT_W-1:0] cnt,
  output pwmStrobeT        strobe
);

  localparam logic [CNT_W-1:0] CNT_TOP     = '1;
  localparam logic [CNT_W-1:0] CNT_PRE_TOP = CNT_TOP - CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE     = CNT_W'(1);

  logic tick;
  logic descQ;
  logic turnTop;
  logic turnBottom;

  pwm_prescaler preI (
    .clk    (clk),
    .rstN   (rstN),
    .clkSel (clkSel),
    .tick   (tick)
  );

  always_comb begin
    turnTop            = !descQ && (cnt == CNT_PRE_TOP);
    turnBottom         = descQ && (cnt == CNT_ONE);
    strobe.tick        = tick;
    strobe.enterTop    = tick && turnTop;
    strobe.enterBottom = tick && turnBottom;
    strobe.descending  = descQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   descQ <= 1'b0;
    else if (tick && turnTop)    descQ <= 1'b1;
    else if (tick && turnBottom) descQ <= 1'b0;
  end

endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwmStrobeT        strobe,
  input  logic             cmpWrEn,
  input  logic [CNT_W-1:0] cmpWrData,
  input  logic [1:0]       modeSel,
  input  logic             flagClrOvf,
  input  logic             flagClrCmp,
  output logic [CNT_W-1:0] cnt,
  output logic             pwmOut,
  output logic             pwmOutEn,
  output logic             ovfFlag,
  output logic             cmpFlag
);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cntNext;
  logic [CNT_W-1:0] ocrBuf;
  logic [CNT_W-1:0] ocrAct;
  logic [CNT_W-1:0] ocrNext;
  logic             cmpHit;
  logic             levelHigh;
  logic             ovfQ;
  logic             cmpQ;
  outModeT          outMode;

  always_comb begin
    cntNext   = strobe.descending ? (cntQ - CNT_W'(1)) : (cntQ + CNT_W'(1));
    ocrNext   = strobe.enterTop ? ocrBuf : ocrAct;
    cmpHit    = strobe.tick && (cntNext == ocrNext);
    // Falling slope includes the match count itself; rising slope stops short of it.
    levelHigh = strobe.descending ? (cntQ <= ocrAct) : (cntQ < ocrAct);
    outMode   = outModeT'(modeSel);
    pwmOutEn  = (outMode == OUT_TRUE) || (outMode == OUT_INV);
    pwmOut    = pwmOutEn && (levelHigh ^ (outMode == OUT_INV));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ   <= '0;
      ocrBuf <= '0;
      ocrAct <= '0;
      ovfQ   <= 1'b0;
      cmpQ   <= 1'b0;
    end else begin
      if (strobe.tick)     cntQ   <= cntNext;
      if (cmpWrEn)         ocrBuf <= cmpWrData;
      if (strobe.enterTop) ocrAct <= ocrBuf;
      if (strobe.enterBottom) ovfQ <= 1'b1;
      else if (flagClrOvf)    ovfQ <= 1'b0;
      if (cmpHit)             cmpQ <= 1'b1;
      else if (flagClrCmp)    cmpQ <= 1'b0;
    end
  end

  assign cnt     = cntQ;
  assign ovfFlag = ovfQ;
  assign cmpFlag = cmpQ;

endmodule

// File: rtl/pwm_phase_timer.sv
module pwm_phase_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       clkSel,
  input  logic [1:0]       modeSel,
  input  logic             cmpWrEn,
  input  logic [CNT_W-1:0] cmpWrData,
  input  logic             flagClrOvf,
  input  logic             flagClrCmp,
  output logic [CNT_W-1:0] cntValue,
  output logic             pwmOut,
  output logic             pwmOutEn,
  output logic             ovfFlag,
  output logic             cmpFlag
);

  pwmStrobeT strobe;

  pwm_ctrl #(.CNT_W(CNT_W)) ctrlI (
    .clk    (clk),
    .rstN   (rstN),
    .clkSel (clkSel),
    .cnt    (cntValue),
    .strobe (strobe)
  );

  pwm_datapath #(.CNT_W(CNT_W)) dpI (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cmpWrEn    (cmpWrEn),
    .cmpWrData  (cmpWrData),
    .modeSel    (modeSel),
    .flagClrOvf (flagClrOvf),
    .flagClrCmp (flagClrCmp),
    .cnt        (cntValue),
    .pwmOut     (pwmOut),
    .pwmOutEn   (pwmOutEn),
    .ovfFlag    (ovfFlag),
    .cmpFlag    (cmpFlag)
  );

endmodule

// File: rtl/pwm_phase_timer_chk.sv
module pwm_phase_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       clkSel,
  input logic [1:0]       modeSel,
  input logic             flagClrOvf,
  input logic             flagClrCmp,
  input logic [CNT_W-1:0] cntValue,
  input logic             pwmOut,
  input logic             pwmOutEn,
  input logic             ovfFlag,
  input logic             cmpFlag
);

  a_r1_unit_step: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cntValue) |-> (cntValue == $past(cntValue) + CNT_W'(1)) ||
                           (cntValue == $past(cntValue) - CNT_W'(1)));

  a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == 3'd0) |=> $stable(cntValue));

  a_r3_ovf_at_bottom: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> (cntValue == '0));

  a_r4_cmp_on_step: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmpFlag) |-> !$stable(cntValue));

  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !flagClrOvf) |=> ovfFlag);

  a_r5_cmp_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (cmpFlag && !flagClrCmp) |=> cmpFlag);

  a_r8_off_modes: assert property (@(posedge clk) disable iff (!rstN)
    !modeSel[1] |-> (!pwmOut && !pwmOutEn));

  a_r8_on_modes: assert property (@(posedge clk) disable iff (!rstN)
    modeSel[1] |-> pwmOutEn);

endmodule

bind pwm_phase_timer pwm_phase_timer_chk #(.CNT_W(CNT_W)) chkI (
  .clk        (clk),
  .rstN       (rstN),
  .clkSel     (clkSel),
  .modeSel    (modeSel),
  .flagClrOvf (flagClrOvf),
  .flagClrCmp (flagClrCmp),
  .cntValue   (cntValue),
  .pwmOut     (pwmOut),
  .pwmOutEn   (pwmOutEn),
  .ovfFlag    (ovfFlag),
  .cmpFlag    (cmpFlag)
);

// File: tb/pwm_phase_timer_tb_top.sv
`timescale 1ns/1ps
module pwm_phase_timer_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic [2:0] clkSel;
  logic [1:0] modeSel;
  logic       cmpWrEn;
  logic [7:0] cmpWrData;
  logic       flagClrOvf;
  logic       flagClrCmp;
  logic [7:0] cntValue;
  logic       pwmOut;
  logic       pwmOutEn;
  logic       ovfFlag;
  logic       cmpFlag;

  int nTests = 0;
  int nFail  = 0;
  int divTab [8] = '{1, 1, 8, 32, 64, 128, 256, 1024};

  always #2 clk = ~clk;

  pwm_phase_timer dut_i (
    .clk(clk), .rstN(rstN), .clkSel(clkSel), .modeSel(modeSel),
    .cmpWrEn(cmpWrEn), .cmpWrData(cmpWrData),
    .flagClrOvf(flagClrOvf), .flagClrCmp(flagClrCmp),
    .cntValue(cntValue), .pwmOut(pwmOut), .pwmOutEn(pwmOutEn),
    .ovfFlag(ovfFlag), .cmpFlag(cmpFlag)
  );

  function automatic int triVal(input int j);
    int m;
    m = j % 510;
    return (m <= 255) ? m : 510 - m;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; clkSel = '0; modeSel = '0; cmpWrEn = 1'b0; cmpWrData = '0;
    flagClrOvf = 1'b0; flagClrCmp = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // Returns at the first sample where the count equals v, reached moving in the given direction.
  task automatic waitAt(input int v, input bit desc);
    int prev;
    prev = cntValue;
    forever begin
      @(negedge clk);
      if (cntValue == v && ((desc && prev > v) || (!desc && prev < v))) break;
      prev = cntValue;
    end
  endtask

  task automatic writeCmp(input int v);
    cmpWrData = 8'(v); cmpWrEn = 1'b1;
    @(negedge clk);
    cmpWrEn = 1'b0;
  endtask

  task automatic sweep(input bit inv, input int lo, input int hi);
    int highs;
    int exp;
    waitAt(255, 1'b0);
    modeSel = inv ? 2'd3 : 2'd2;
    writeCmp(lo);
    for (int k = lo; k <= hi; k++) begin
      waitAt(255, 1'b0);
      // R10: level at the top for the freshly loaded value
      chk(pwmOut == ((k == 255) ^ inv), "R10 level at top", pwmOut, (k == 255) ^ inv);
      highs = 0;
      if (k < hi) begin cmpWrData = 8'(k + 1); cmpWrEn = 1'b1; end
      for (int s = 0; s < 510; s++) begin
        if (s > 0) begin
          @(negedge clk);
          cmpWrEn = 1'b0;
        end
        if (pwmOut) highs++;
      end
      exp = (k == 255) ? 510 : 2 * k;
      if (inv) exp = 510 - exp;
      chk(highs == exp, inv ? "R7 inverted duty" : "R6 true duty", highs, exp);
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int mism, firstOvf, lowSeen, highSeen, start, k;
    doReset();
    chk(cntValue == 0, "R11 count", cntValue, 0);
    chk(!pwmOut && !pwmOutEn, "R11 pin off", {pwmOut, pwmOutEn}, 0);
    chk(!ovfFlag && !cmpFlag, "R11 flags", {ovfFlag, cmpFlag}, 0);

    repeat (20) @(negedge clk);
    chk(cntValue == 0, "R2 select 0 holds", cntValue, 0);

    // R1 and R3: steps every clock
    clkSel = 3'd1; mism = 0; firstOvf = -1;
    for (int j = 0; j < 1100; j++) begin
      @(negedge clk);
      if (cntValue != triVal(j)) mism++;
      if (ovfFlag && firstOvf < 0) firstOvf = j;
    end
    chk(mism == 0, "R1 triangle sequence mismatches", mism, 0);
    chk(firstOvf == 510, "R3 first bottom flag sample", firstOvf, 510);

    // R5
    flagClrOvf = 1'b1; @(negedge clk); flagClrOvf = 1'b0;
    chk(ovfFlag == 0, "R5 write-1 clear", ovfFlag, 0);
    waitAt(1, 1'b1);
    flagClrOvf = 1'b1; @(negedge clk); flagClrOvf = 1'b0;
    chk(cntValue == 0 && ovfFlag == 1, "R5 set beats clear", ovfFlag, 1);
    flagClrOvf = 1'b1; @(negedge clk); flagClrOvf = 1'b0;
    chk(ovfFlag == 0, "R5 clear after set", ovfFlag, 0);

    // R4 both slopes with value 100
    writeCmp(100);
    waitAt(255, 1'b0);
    waitAt(150, 1'b1);
    flagClrCmp = 1'b1; @(negedge clk); flagClrCmp = 1'b0;
    waitAt(101, 1'b1);
    chk(cmpFlag == 0, "R4 no flag before falling match", cmpFlag, 0);
    @(negedge clk);
    chk(cntValue == 100 && cmpFlag == 1, "R4 falling match flag", cmpFlag, 1);
    waitAt(50, 1'b0);
    flagClrCmp = 1'b1; @(negedge clk); flagClrCmp = 1'b0;
    waitAt(99, 1'b0);
    chk(cmpFlag == 0, "R4 no flag before rising match", cmpFlag, 0);
    @(negedge clk);
    chk(cntValue == 100 && cmpFlag == 1, "R4 rising match flag", cmpFlag, 1);

    // R8 with a value that would drive high
    writeCmp(255);
    waitAt(255, 1'b0);
    modeSel = 2'd0; @(negedge clk);
    chk(!pwmOut && !pwmOutEn, "R8 mode 0 off", {pwmOut, pwmOutEn}, 0);
    modeSel = 2'd1; @(negedge clk);
    chk(!pwmOut && !pwmOutEn, "R8 mode 1 off", {pwmOut, pwmOutEn}, 0);
    modeSel = 2'd2; @(negedge clk);
    chk(pwmOut && pwmOutEn, "R8 R6 mode 2 driven high at 255", {pwmOut, pwmOutEn}, 3);

    // R9 and R10: mid-period write from 255 to 0
    waitAt(10, 1'b1);
    writeCmp(0);
    lowSeen = 0;
    while (cntValue != 255) begin
      if (!pwmOut) lowSeen++;
      @(negedge clk);
    end
    chk(lowSeen == 0, "R9 buffered write held until top", lowSeen, 0);
    chk(pwmOut == 0, "R10 drop at top without match", pwmOut, 0);
    highSeen = 0;
    for (int s = 0; s < 509; s++) begin
      @(negedge clk);
      if (pwmOut) highSeen++;
    end
    chk(highSeen == 0, "R6 value 0 constant low", highSeen, 0);

    sweep(1'b0, 0, 255);
    sweep(1'b1, 0, 3);
    sweep(1'b1, 252, 255);

    // R2 divide ratios
    clkSel = 3'd0; @(negedge clk);
    for (int sel = 1; sel <= 7; sel++) begin
      clkSel = 3'(sel);
      start = cntValue; k = 0;
      do begin @(negedge clk); k++; end while (cntValue == start && k < 3000);
      chk(k == divTab[sel] + 1, "R2 first step after select change", k, divTab[sel] + 1);
      start = cntValue; k = 0;
      do begin @(negedge clk); k++; end while (cntValue == start && k < 3000);
      chk(k == divTab[sel], "R2 step interval", k, divTab[sel]);
    end
    clkSel = 3'd0; @(negedge clk);
    start = cntValue;
    repeat (30) @(negedge clk);
    chk(cntValue == start, "R2 select 0 holds later", cntValue, start);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule